// File: doc/BRIEF.md
# Decode-Stage Branch Resolver with Static Policies

This block is the control-flow unit for a five-stage in-order pipeline that resolves conditional equal-branches in the decode stage. In that stage it compares the two source operands of a decoded branch and computes the branch target. It then chooses where fetch goes next, tells the fetch stage whether to hold, and bubbles the fetch/decode register when the instruction just fetched must not run. The block owns the fetch program counter and the valid bit of the fetch/decode register. The surrounding pipeline supplies the decoded branch flag, the operand values, the sign-extended word displacement, a per-instruction predict bit and the address of the decoding instruction.

A two-bit policy input selects one of four static strategies. Full stall spends one bubble on every branch. Predict-fall-through squashes only taken branches. Direction prediction guesses backward branches taken and forward branches not taken, and a hint-enable input lets the instruction's own predict bit override that guess. The architectural delay slot always executes the instruction after the branch. A mispredict strobe and two saturating counters, one for branches and one for mispredicts, let the penalty of each policy be measured.

Top module: `branch_redirect_unit`

## Requirements
- R1: A synchronous active-high reset sets the fetch PC to 0, clears the fetch/decode valid bit, clears both counters and selects the stall policy.
- R2: A branch is taken when the two operand values are equal, and its target is the branch address plus 4 plus four times the displacement. The fetch PC after a taken branch's decode cycle is that target, with select code 1.
- R3: Under policy 0 (stall), every branch in decode raises the fetch stall and the squash. The fetch PC then goes to the target if taken, or else to the branch address plus 4 (select code 2). No mispredict is flagged.
- R4: Under policy 1 (predict not taken), a not-taken branch costs nothing: no squash, and fetch continues at fetch PC plus 4 (select code 0). A taken branch squashes, redirects to the target and flags a mispredict.
- R5: Under policy 2 (direction), the guess is taken for a negative displacement and not taken otherwise. When hint enable is high, the predict bit replaces the guess. A guess of taken, or an actual taken outcome, squashes. A wrong guess flags a mispredict, and a wrong taken guess goes to branch address plus 4 (select code 2).
- R6: Under policy 3 (delay slot), nothing is ever squashed. Fetch goes to the target if taken, or else continues at fetch PC plus 4.
- R7: The fetch/decode valid bit in the cycle after a decode cycle equals the inverse of that cycle's squash.
- R8: The branch counter advances once per branch in decode and the mispredict counter once per mispredict. Both stop at their all-ones value.
- R9: The policy input is sampled only in cycles with no branch in decode, so a branch uses the policy latched before it.
- R10: A branch flag presented while the fetch/decode valid bit is low is ignored: no squash, stall or mispredict, fetch goes to PC plus 4, and no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_i | input | 2 | Branch policy: 0 stall, 1 not taken, 2 direction, 3 delay slot |
| hint_en_i | input | 1 | Lets the per-instruction predict bit override the direction guess |
| id_branch_i | input | 1 | Instruction in decode is a conditional equal-branch |
| id_pc_i | input | ADDR_W | Address of the instruction in decode |
| id_rs_val_i | input | DATA_W | First compared operand |
| id_rt_val_i | input | DATA_W | Second compared operand |
| id_disp_i | input | ADDR_W | Sign-extended word displacement |
| id_hint_i | input | 1 | Per-instruction predict-taken bit |
| fetch_pc_o | output | ADDR_W | Address being fetched |
| npc_sel_o | output | 2 | Next-PC source: 0 sequential, 1 target, 2 branch plus 4 |
| if_stall_o | output | 1 | Fetch held for a branch under the stall policy |
| ifid_squash_o | output | 1 | Replace the fetched instruction with a bubble |
| ifid_valid_o | output | 1 | Valid bit of the fetch/decode register |
| mispredict_o | output | 1 | Strobe for a wrong guess in this decode cycle |
| branch_cnt_o | output | CNT_W | Saturating count of branches resolved |
| mispred_cnt_o | output | CNT_W | Saturating count of mispredicts |

## Verification
The squash, stall, mispredict and select outputs are combinational, so they are due in the same cycle as the decode inputs. The bench reads them a short delay after driving the inputs on the falling edge. The fetch PC, the valid bit, the counters and the latched policy each pass through one register, so they are due one edge later. The bench reads them on the next falling edge, after updating its own model for that edge. The stimulus covers every combination of policy, hint enable, predict bit, displacement sign and outcome. It then adds a policy change during a branch, a branch behind a bubble, and enough mispredicts to saturate the counters.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic [1:0] {
    POL_STALL      = 2'd0,
    POL_NOT_TAKEN  = 2'd1,
    POL_DIRECTION  = 2'd2,
    POL_DELAY_SLOT = 2'd3
  } policy_e;

  typedef enum logic [1:0] {
    NPC_SEQ    = 2'd0,
    NPC_TARGET = 2'd1,
    NPC_REPLAY = 2'd2
  } npc_sel_e;
endpackage

// File: rtl/bru_resolve.sv
module bru_resolve #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [ADDR_W-1:0] br_pc,
  input  logic [ADDR_W-1:0] disp,
  input  logic              hint_en,
  input  logic              hint,
  output logic              taken,
  output logic              guess_taken,
  output logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] fall_thru
);
  localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

  function automatic logic [ADDR_W-1:0] calc_target(
    input logic [ADDR_W-1:0] pc, input logic [ADDR_W-1:0] d);
    return pc + INSN_BYTES + (d << 2);
  endfunction

  function automatic logic calc_guess(
    input logic en, input logic bit_hint, input logic [ADDR_W-1:0] d);
    return en ? bit_hint : d[ADDR_W-1];
  endfunction

  always_comb begin
    taken       = (op_a == op_b);
    guess_taken = calc_guess(hint_en, hint, disp);
    target      = calc_target(br_pc, disp);
    fall_thru   = br_pc + INSN_BYTES;
  end
endmodule

// File: rtl/bru_policy.sv
module bru_policy
  import bru_pkg::*;
(
  input  logic     br_live,
  input  policy_e  pol,
  input  logic     taken,
  input  logic     guess_taken,
  output logic     squash,
  output logic     stall,
  output logic     mispredict,
  output npc_sel_e sel
);
  always_comb begin
    squash     = 1'b0;
    stall      = 1'b0;
    mispredict = 1'b0;
    sel        = NPC_SEQ;
    if (br_live) begin
      unique case (pol)
        POL_STALL: begin
          squash = 1'b1;
          stall  = 1'b1;
          sel    = taken ? NPC_TARGET : NPC_REPLAY;
        end
        POL_NOT_TAKEN: begin
          squash     = taken;
          mispredict = taken;
          sel        = taken ? NPC_TARGET : NPC_SEQ;
        end
        POL_DIRECTION: begin
          squash     = guess_taken | taken;
          mispredict = guess_taken ^ taken;
          if (taken)            sel = NPC_TARGET;
          else if (guess_taken) sel = NPC_REPLAY;
          else                  sel = NPC_SEQ;
        end
        default: begin
          sel = taken ? NPC_TARGET : NPC_SEQ;
        end
      endcase
    end
  end
endmodule

// File: rtl/bru_sat_counter.sv
module bru_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                    count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (count == TOP) |=> (count == TOP));
endmodule

// File: rtl/branch_redirect_unit.sv
module branch_redirect_unit
  import bru_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        policy_i,
  input  logic              hint_en_i,
  input  logic              id_branch_i,
  input  logic [ADDR_W-1:0] id_pc_i,
  input  logic [DATA_W-1:0] id_rs_val_i,
  input  logic [DATA_W-1:0] id_rt_val_i,
  input  logic [ADDR_W-1:0] id_disp_i,
  input  logic              id_hint_i,
  output logic [ADDR_W-1:0] fetch_pc_o,
  output logic [1:0]        npc_sel_o,
  output logic              if_stall_o,
  output logic              ifid_squash_o,
  output logic              ifid_valid_o,
  output logic              mispredict_o,
  output logic [CNT_W-1:0]  branch_cnt_o,
  output logic [CNT_W-1:0]  mispred_cnt_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] pc_q, pc_next, target, fall_thru;
  logic              valid_q;
  policy_e           pol_q;
  npc_sel_e          sel;
  logic              br_live, taken, guess_taken, squash, stall, mispredict;

  assign br_live = valid_q & id_branch_i;

  bru_resolve #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_resolve (
    .op_a(id_rs_val_i), .op_b(id_rt_val_i), .br_pc(id_pc_i), .disp(id_disp_i),
    .hint_en(hint_en_i), .hint(id_hint_i), .taken(taken),
    .guess_taken(guess_taken), .target(target), .fall_thru(fall_thru));

  bru_policy u_policy (
    .br_live(br_live), .pol(pol_q), .taken(taken), .guess_taken(guess_taken),
    .squash(squash), .stall(stall), .mispredict(mispredict), .sel(sel));

  always_comb begin
    unique case (sel)
      NPC_TARGET: pc_next = target;
      NPC_REPLAY: pc_next = fall_thru;
      default:    pc_next = pc_q + STEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      valid_q <= 1'b0;
      pol_q   <= POL_STALL;
    end else begin
      pc_q    <= pc_next;
      valid_q <= ~squash;
      if (!br_live) pol_q <= policy_e'(policy_i);
    end
  end

  bru_sat_counter #(.W(CNT_W)) u_br_cnt (
    .clk(clk), .rst(rst), .inc(br_live), .count(branch_cnt_o));
  bru_sat_counter #(.W(CNT_W)) u_mp_cnt (
    .clk(clk), .rst(rst), .inc(mispredict), .count(mispred_cnt_o));

  assign fetch_pc_o    = pc_q;
  assign npc_sel_o     = sel;
  assign if_stall_o    = stall;
  assign ifid_squash_o = squash;
  assign ifid_valid_o  = valid_q;
  assign mispredict_o  = mispredict;

  // R7
  bubble_after_squash_chk: assert property (@(posedge clk) disable iff (rst)
    squash |=> !valid_q);
  // R6
  slot_never_flushed_chk: assert property (@(posedge clk) disable iff (rst)
    (br_live && pol_q == POL_DELAY_SLOT) |-> !squash);
  // R3
  stall_policy_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (br_live && pol_q == POL_STALL) |-> (squash && !mispredict));
  // R4
  mispredict_flushes_chk: assert property (@(posedge clk) disable iff (rst)
    mispredict |-> squash);
  // R9
  policy_held_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
    br_live |=> (pol_q == $past(pol_q)));
  // R2
  taken_goes_to_target_chk: assert property (@(posedge clk) disable iff (rst)
    (br_live && taken) |=> (pc_q == $past(target)));
  // R10
  idle_decode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> (!squash && !stall && !mispredict));
endmodule

// File: tb/sim_branch_redirect_unit.sv
module sim_branch_redirect_unit;
  localparam int AW = 32;
  localparam int DW = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    policy_i;
  logic          hint_en_i, id_branch_i, id_hint_i;
  logic [AW-1:0] id_pc_i, id_disp_i;
  logic [DW-1:0] id_rs_val_i, id_rt_val_i;
  logic [AW-1:0] fetch_pc_o;
  logic [1:0]    npc_sel_o;
  logic          if_stall_o, ifid_squash_o, ifid_valid_o, mispredict_o;
  logic [CW-1:0] branch_cnt_o, mispred_cnt_o;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] m_pc;
  logic          m_valid;
  logic [1:0]    m_pol;
  int            m_bcnt, m_mcnt;

  always #10 clk = ~clk;

  branch_redirect_unit #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .policy_i(policy_i), .hint_en_i(hint_en_i),
    .id_branch_i(id_branch_i), .id_pc_i(id_pc_i), .id_rs_val_i(id_rs_val_i),
    .id_rt_val_i(id_rt_val_i), .id_disp_i(id_disp_i), .id_hint_i(id_hint_i),
    .fetch_pc_o(fetch_pc_o), .npc_sel_o(npc_sel_o), .if_stall_o(if_stall_o),
    .ifid_squash_o(ifid_squash_o), .ifid_valid_o(ifid_valid_o),
    .mispredict_o(mispredict_o), .branch_cnt_o(branch_cnt_o),
    .mispred_cnt_o(mispred_cnt_o));

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] pol_in, input logic hen, input logic br,
                     input logic [AW-1:0] pc, input logic [DW-1:0] a,
                     input logic [DW-1:0] b, input logic [AW-1:0] disp,
                     input logic hint);
    logic live, tk, gs, e_sq, e_st, e_mp;
    logic [1:0] e_sel;
    logic [AW-1:0] e_next;
    string tag;
    policy_i = pol_in; hint_en_i = hen; id_branch_i = br; id_pc_i = pc;
    id_rs_val_i = a; id_rt_val_i = b; id_disp_i = disp; id_hint_i = hint;
    #2;
    live = m_valid && br;
    tk   = (a == b);
    gs   = hen ? hint : disp[AW-1];
    e_sq = 0; e_st = 0; e_mp = 0; e_sel = 2'd0;
    tag  = live ? (m_pol == 0 ? "R3" : m_pol == 1 ? "R4" : m_pol == 2 ? "R5" : "R6") : "R10";
    if (live) begin
      // cost view: which policy pays a bubble, which one reports a wrong guess
      if (m_pol == 0)      begin e_sq = 1; e_st = 1; end
      else if (m_pol == 1) begin e_sq = tk; e_mp = tk; end
      else if (m_pol == 2) begin e_sq = tk || gs; e_mp = (tk != gs); end
      if (tk) e_sel = 2'd1;
      else if (m_pol == 0 || (m_pol == 2 && gs)) e_sel = 2'd2;
    end
    e_next = (e_sel == 2'd1) ? pc + 4 + disp * 4 :
             (e_sel == 2'd2) ? pc + 4 : m_pc + 4;
    chk(tag, "squash", ifid_squash_o, e_sq);
    chk(tag, "stall", if_stall_o, e_st);
    chk(tag, "mispredict", mispredict_o, e_mp);
    chk(tk && live ? "R2" : tag, "npc_sel", npc_sel_o, e_sel);
    @(posedge clk);
    @(negedge clk);
    m_pc = e_next;
    m_valid = !e_sq;
    if (live && m_bcnt < 15) m_bcnt++;
    if (e_mp && m_mcnt < 15) m_mcnt++;
    if (!live) m_pol = pol_in;
    chk(tk && live ? "R2" : tag, "fetch_pc", fetch_pc_o, m_pc);
    chk("R7", "ifid_valid", ifid_valid_o, m_valid);
    chk("R8", "branch_cnt", branch_cnt_o, m_bcnt);
    chk("R8", "mispred_cnt", mispred_cnt_o, m_mcnt);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; policy_i = 0; hint_en_i = 0; id_branch_i = 0; id_pc_i = 0;
    id_rs_val_i = 0; id_rt_val_i = 0; id_disp_i = 0; id_hint_i = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "fetch_pc", fetch_pc_o, 0);
    chk("R1", "ifid_valid", ifid_valid_o, 0);
    chk("R1", "branch_cnt", branch_cnt_o, 0);
    chk("R1", "mispred_cnt", mispred_cnt_o, 0);
    rst = 0;
    m_pc = 0; m_valid = 0; m_pol = 0; m_bcnt = 0; m_mcnt = 0;

    // full sweep of policy, hint enable, predict bit, displacement sign, outcome
    for (int p = 0; p < 4; p++)
      for (int he = 0; he < 2; he++)
        for (int hb = 0; hb < 2; hb++)
          for (int dn = 0; dn < 2; dn++)
            for (int t = 0; t < 2; t++) begin
              cyc(2'(p), 1'b0, 1'b0, m_pc, 8'h11, 8'h22, 32'd0, 1'b0);
              cyc(2'(p), 1'(he), 1'b1, m_pc - 4, 8'h5A, t ? 8'h5A : 8'hA5,
                  dn ? -32'sd3 : 32'sd6, 1'(hb));
            end

    // R9: policy change during a branch is deferred
    cyc(2'd1, 0, 0, m_pc, 8'h1, 8'h2, 0, 0);
    cyc(2'd3, 0, 1, m_pc - 4, 8'h7, 8'h7, 32'd2, 0);
    cyc(2'd3, 0, 0, m_pc, 8'h1, 8'h2, 0, 0);
    cyc(2'd0, 0, 1, m_pc - 4, 8'h7, 8'h7, 32'd2, 0);

    // R10: branch flag behind a bubble is ignored
    cyc(2'd1, 0, 0, m_pc, 8'h1, 8'h2, 0, 0);
    cyc(2'd1, 0, 1, m_pc - 4, 8'h3, 8'h3, 32'd9, 0);
    cyc(2'd1, 0, 1, m_pc - 4, 8'h3, 8'h3, 32'd9, 0);

    // R8: saturate the mispredict counter
    for (int k = 0; k < 18; k++) begin
      cyc(2'd1, 0, 0, m_pc, 8'h1, 8'h2, 0, 0);
      cyc(2'd1, 0, 1, m_pc - 4, 8'h4, 8'h4, -32'sd1, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule